// File: doc/BRIEF.md
# Split-Resolution 14-bit Pulse-Width DAC

This block turns a 14-bit code into a pulse train on a single pin, for driving an analog control line through an external low-pass filter. Each output period is 128 base ticks long. A tick strobe from outside the block sets the tick rate, for example one tick every 0.33 µs. The upper seven code bits set a coarse pulse width of 0 to 127 ticks at the start of every period. The lower seven bits give a fine count N. Exactly N periods in every 128-period frame are one tick longer than the coarse width, and those longer periods are spread evenly across the frame.

Software reaches the block through two byte registers on a simple register bus. A write to the low byte only stages data. A write to the high byte commits the full code at once. The committed code reaches the output at the next period boundary, so no running period is ever cut short. The high byte also holds an enable bit. When the enable is clear, the pin follows a plain port data bit instead of the PWM.

Top module: `spwm_dac`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0, the enable is off, the pin follows `port_bit`, and the committed code is 0.
- R2: The high register is at address 0xD3 and the low register is at 0xD2. Reads return the stored bytes combinationally. High bit 6 always reads 0, whatever was written to it. Any other address reads 0.
- R3: A write to the low register does not change the waveform on the pin. The staged byte is used only when the high register is written later.
- R4: A write to the high register commits the code {high[5:0], low[7:0]} in one step. The new code takes effect at the next period boundary, and the period running when the write happens keeps its old length.
- R5: Each period is 128 ticks long, counted by tick position 0 to 127. The pin is high for ticks 0 to L-1 and low for the rest of the period. L equals the coarse width W = code[13:7] (high[5:0] followed by low[7]), plus one for an extended period.
- R6: With fine value N = code[6:0], any 128 consecutive periods under a fixed code carry 128*W + N high ticks in total.
- R7: The period with frame index f (0 to 127, advancing once per period) is extended exactly when the 7-bit bit-reversal of f is less than N.
- R8: A code of 0 keeps the pin low for the whole period. W = 127 on an extended period keeps the pin high for all 128 ticks.
- R9: High bit 7 is the enable. When it is 1 the pin carries the PWM; when it is 0 the pin equals `port_bit`.
- R10: The tick position and frame index advance only in cycles where `tick_en` is 1. Between ticks the pin holds its level.
- R11: Writes to any address other than 0xD2 and 0xD3 change no register and leave the pin unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base tick strobe; one tick per cycle where high |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| port_bit | input | 1 | Port data bit used while the PWM is disabled |
| pwm_pin | output | 1 | Output pin |

## Verification
The bench builds the block with its default parameters: 7 coarse bits and 7 fine bits, so a period is 128 ticks and a frame is 128 periods. It sweeps all 128 coarse widths and measures each pulse directly. It then runs complete frames for several fine values, including 0, 1, 64 and 127 at both ends of the coarse range. This brings the frame totals, the placement of the extended periods and the full-high period within reach. A section with a sparse tick strobe and a mid-period commit covers the hold behaviour between ticks and the untruncated boundary.

// File: rtl/spwm_pkg.sv
// Package: shared widths and the default register map of the split-resolution DAC.
// Assumes byte-wide registers and a 7+7 bit split of the 14-bit code.
package spwm_pkg;
    localparam int BYTE_W   = 8;
    localparam int COARSE_W = 7;
    localparam int FINE_W   = 7;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] ADDR_LO_DEF = 8'hD2;
    localparam logic [ADDR_W-1:0] ADDR_HI_DEF = 8'hD3;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spwm_regs.sv
// Module: register file of the DAC. Holds the staged low byte, the high byte
// (enable plus upper code bits) and the committed 14-bit code.
// Assumes one write per cycle; the commit happens on every high-byte write.
module spwm_regs
    import spwm_pkg::*;
#(
    parameter int               AW      = ADDR_W,
    parameter logic [AW-1:0]    A_LO    = ADDR_LO_DEF,
    parameter logic [AW-1:0]    A_HI    = ADDR_HI_DEF,
    parameter int               CODE_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  byte_t             wdata,
    output byte_t             rdata,
    output logic              enable,
    output logic [CODE_W-1:0] code
);
    localparam int HI_CODE_BITS = CODE_W - BYTE_W;

    byte_t lo_q;
    byte_t hi_q;

    wire wr_lo = wr && (addr == A_LO);
    wire wr_hi = wr && (addr == A_HI);

    // Staging register: a low-byte write changes only this byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (wr_lo) lo_q <= wdata;
    end

    // High byte and commit: the whole code is taken in one step on a high write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            code <= '0;
        end else if (wr_hi) begin
            hi_q <= {wdata[BYTE_W-1], 1'b0, wdata[HI_CODE_BITS-1:0]};
            code <= {wdata[HI_CODE_BITS-1:0], lo_q};
        end
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        if (addr == A_HI)      rdata = hi_q;
        else if (addr == A_LO) rdata = lo_q;
        else                   rdata = '0;
    end

    assign enable = hi_q[BYTE_W-1];

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != A_HI) |=> $stable(code)); // R3
    AST_COMMIT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> code == {$past(wdata[HI_CODE_BITS-1:0]), $past(lo_q)}); // R4
endmodule

// File: rtl/spwm_timebase.sv
// Module: tick position counter inside a period and frame index counter.
// Assumes the period and the frame are both powers of two and wrap naturally.
module spwm_timebase #(
    parameter int CW = 7,
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] pos,
    output logic [FW-1:0] frame_idx,
    output logic          period_end
);
    assign period_end = tick && (pos == {CW{1'b1}});

    // Tick position: advances by one on each tick strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (tick) pos <= pos + 1'b1;
    end

    // Frame index: advances once per completed period.
    always_ff @(posedge clk) begin
        if (!rst_n)          frame_idx <= '0;
        else if (period_end) frame_idx <= frame_idx + 1'b1;
    end

    AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos)); // R10
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(frame_idx)); // R10
endmodule

// File: rtl/spwm_shaper.sv
// Module: loads the pulse length for each period at the boundary and compares
// it with the tick position. Extension uses the bit-reversed next frame index.
// Assumes the code input is stable except on commit writes.
module spwm_shaper #(
    parameter int CW = 7,
    parameter int FW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           period_end,
    input  logic [CW-1:0]  pos,
    input  logic [FW-1:0]  frame_idx,
    input  logic [CW+FW-1:0] code,
    output logic           level
);
    logic [FW-1:0] next_idx;
    logic [FW-1:0] next_rev;
    logic          stretch;
    logic [CW:0]   len_q;

    assign next_idx = frame_idx + 1'b1;

    // Bit reversal spreads the extended periods evenly over the frame.
    for (genvar i = 0; i < FW; i++) begin : g_rev
        assign next_rev[i] = next_idx[FW-1-i];
    end

    assign stretch = (next_rev < code[FW-1:0]);

    // Active length: updated only at a period boundary, so no period is cut.
    always_ff @(posedge clk) begin
        if (!rst_n)          len_q <= '0;
        else if (period_end) len_q <= {1'b0, code[CW+FW-1:FW]} + {{CW{1'b0}}, stretch};
    end

    assign level = ({1'b0, pos} < len_q);

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(len_q)); // R4
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && code == '0) |=> !level); // R8
endmodule

// File: rtl/spwm_dac.sv
// Module: top of the split-resolution 14-bit pulse-width DAC. Ties the
// register file, time base and pulse shaper together and muxes the pin.
// Assumes tick_en is a single-cycle strobe in the clk domain.
module spwm_dac
    import spwm_pkg::*;
#(
    parameter int            CW   = COARSE_W,
    parameter int            FW   = FINE_W,
    parameter logic [7:0]    A_LO = ADDR_LO_DEF,
    parameter logic [7:0]    A_HI = ADDR_HI_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [7:0] bus_addr,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       port_bit,
    output logic       pwm_pin
);
    localparam int CODE_W = CW + FW;

    logic              en;
    logic [CODE_W-1:0] code;
    logic [CW-1:0]     pos;
    logic [FW-1:0]     fidx;
    logic              pend;
    logic              lvl;

    spwm_regs #(.AW(8), .A_LO(A_LO), .A_HI(A_HI), .CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .rdata(bus_rdata), .enable(en), .code(code)
    );

    spwm_timebase #(.CW(CW), .FW(FW)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .pos(pos), .frame_idx(fidx), .period_end(pend)
    );

    spwm_shaper #(.CW(CW), .FW(FW)) u_shp (
        .clk(clk), .rst_n(rst_n), .period_end(pend), .pos(pos),
        .frame_idx(fidx), .code(code), .level(lvl)
    );

    // Pin mux: the enable bit hands the pin to the PWM or to the port bit.
    assign pwm_pin = en ? lvl : port_bit;

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick_en && !bus_wr) |=> $stable(pwm_pin)); // R10
endmodule

// File: tb/spwm_dac_tb.sv
module spwm_dac_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       port_bit = 1'b0;
    logic       pwm_pin;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench reference state, built from the requirements
    logic [7:0]  m_lo, m_hi;
    logic [13:0] m_code;
    int          m_len;
    int          ticks;
    bit          live = 0;

    always #2.5 clk = ~clk;

    spwm_dac u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_bit(port_bit), .pwm_pin(pwm_pin)
    );

    function automatic int rev7(input int f);
        int r = 0;
        for (int i = 0; i < 7; i++) if (f[i]) r |= (1 << (6 - i));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: registers, commit and the period length per R4, R5, R7
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo <= 0; m_hi <= 0; m_code <= 0; m_len <= 0; ticks <= 0;
        end else begin
            if (bus_wr && bus_addr == 8'hD2) m_lo <= bus_wdata;
            if (bus_wr && bus_addr == 8'hD3) begin
                m_hi   <= bus_wdata & 8'hBF;
                m_code <= {bus_wdata[5:0], m_lo};
            end
            if (tick_en) begin
                ticks <= ticks + 1;
                if (ticks % 128 == 127)
                    m_len <= int'(m_code[13:7]) +
                             ((rev7(((ticks / 128) + 1) % 128) < int'(m_code[6:0])) ? 1 : 0);
            end
        end
    end

    // Cycle-by-cycle pin comparison (R5, R7, R9, R11)
    always @(negedge clk) begin
        if (live) begin
            automatic bit exp_pin = m_hi[7] ? ((ticks % 128) < m_len) : port_bit;
            if (pwm_pin !== exp_pin) check(0, "R5/R7 pin", pwm_pin, exp_pin);
            else checks++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, req, bus_rdata, exp);
    endtask

    task automatic set_code(input int w, input int n, input bit en);
        wr(8'hD2, {w[0], n[6:0]});
        wr(8'hD3, {en, 1'b0, w[6:1]});
    endtask

    task automatic to_period_start();
        @(negedge clk);
        while (ticks % 128 != 0) @(negedge clk);
    endtask

    // high ticks in one period, starting at a period boundary
    task automatic measure_period(output int hi);
        to_period_start();
        hi = 0;
        for (int i = 0; i < 128; i++) begin
            if (i > 0) @(negedge clk);
            hi += pwm_pin;
        end
    endtask

    task automatic frame_test(input int w, input int n);
        int total = 0, full = 0, per = 0;
        set_code(w, n, 1'b1);
        to_period_start();
        to_period_start();
        for (int p = 0; p < 128; p++) begin
            per = 0;
            for (int i = 0; i < 128; i++) begin
                if (p > 0 || i > 0) @(negedge clk);
                per += pwm_pin;
            end
            total += per;
            if (per == 128) full++;
        end
        check(total == 128 * w + n, "R6 frame total", total, 128 * w + n);
        if (w == 127) check(full == n, "R8 full-high periods", full, n);
        if (w == 0 && n == 0) check(total == 0, "R8 zero code low", total, 0);
    endtask

    initial begin
        int hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        tick_en = 1'b1;
        // R1 reset state
        rd(8'hD2, 8'h00, "R1 low reset");
        rd(8'hD3, 8'h00, "R1 high reset");
        port_bit = 1'b1; #1;
        check(pwm_pin === 1'b1, "R1 pin follows port", pwm_pin, 1);
        port_bit = 1'b0; #1;
        check(pwm_pin === 1'b0, "R1 pin follows port", pwm_pin, 0);
        // R2 map and unused bit
        wr(8'hD2, 8'hA5);
        rd(8'hD2, 8'hA5, "R2 low readback");
        wr(8'hD3, 8'h7F);
        rd(8'hD3, 8'h3F, "R2 bit6 reads 0");
        rd(8'h55, 8'h00, "R2 unmapped read");
        // R11 stray writes
        wr(8'hD4, 8'hFF);
        wr(8'hD1, 8'hFF);
        rd(8'hD2, 8'hA5, "R11 low untouched");
        rd(8'hD3, 8'h3F, "R11 high untouched");
        // R9 enable off with a nonzero code: pin follows port
        port_bit = 1'b1;
        repeat (130) @(negedge clk);
        check(pwm_pin === 1'b1, "R9 disabled pin", pwm_pin, 1);
        port_bit = 1'b0;
        // R5 sweep over every coarse width
        for (int w = 0; w < 128; w++) begin
            set_code(w, 0, 1'b1);
            to_period_start();
            measure_period(hi);
            check(hi == w, "R5 coarse width", hi, w);
        end
        // R3 low write alone leaves the width unchanged
        set_code(40, 0, 1'b1);
        to_period_start();
        wr(8'hD2, 8'hFF);
        to_period_start();
        measure_period(hi);
        check(hi == 40, "R3 staged only", hi, 40);
        // R4 mid-period commit keeps the running period
        set_code(90, 0, 1'b1);
        to_period_start();
        measure_period(hi);
        to_period_start();
        repeat (20) @(negedge clk);
        wr(8'hD3, 8'h80 | 8'(10 >> 1));
        hi = 0;
        while (ticks % 128 != 0) begin hi += pwm_pin; @(negedge clk); end
        check(hi == 90 - 22, "R4 period not cut", hi, 68);
        // R10 sparse ticks
        set_code(30, 0, 1'b1);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            tick_en = (k % 3 == 0);
        end
        @(negedge clk);
        tick_en = 1'b1;
        check(1'b1, "R10 sparse ticks compared per cycle", 1, 1);
        // R6, R7, R8 full frames
        frame_test(5, 1);
        frame_test(0, 64);
        frame_test(127, 127);
        frame_test(127, 0);
        frame_test(0, 0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        live = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule